// File: doc/BRIEF.md
# Dynamic Two-Input Lookup Logic Unit

This unit evaluates an arbitrary two-input boolean function independently on every bit position of two 64-bit operands. The function is not fixed at design time and is not an immediate field. It is a 4-bit truth table taken at run time from a nibble of a third operand, so each operation can apply a different function. A single select input decides which of the two lowest nibbles of that table operand is used.

For each bit position the unit builds a 2-bit index from the operand bits. The bit from the second operand is the upper index bit and the bit from the first operand is the lower one. The result bit is the truth-table bit at that index, counted from the least significant end of the chosen nibble. The result is registered, and a one-cycle done pulse follows each valid strobe.

Two passes with opposite select values, followed by a bitwise multiplex on a third operand (itself built from further passes), give a fully dynamic three-input lookup.

Top module: `dyn_lut2_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_done` is 0 and `res_out` is all zeros after that edge.
- R2: With `tbl_hi` = 0, the truth table is `tbl_reg[3:0]`.
- R3: With `tbl_hi` = 1, the truth table is `tbl_reg[7:4]`.
- R4: For bit i, the index is {`src_b[i]`, `src_a[i]`}, and `res_out[i]` equals bit number index of the selected nibble (bit 0 is its least significant bit).
- R5: Every bit position is computed independently of all other positions, across all 64 bits.
- R6: Bits of `tbl_reg` outside the selected nibble have no effect on `res_out`.
- R7: `res_done` is high for exactly the one cycle after each cycle with `in_valid` high, and low otherwise.
- R8: `res_out` keeps its value on every cycle with no valid strobe.
- R9: Two passes with `tbl_hi` = 0 and 1 on the same table, merged bit by bit under a third operand through further passes (AND-NOT with table 4'b0010, AND with 4'b1000, OR with 4'b1110), give an eight-entry dynamic three-input lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are presented this cycle |
| src_a | input | 64 | First operand, low index bit |
| src_b | input | 64 | Second operand, high index bit |
| tbl_reg | input | 64 | Operand that holds the truth-table nibbles |
| tbl_hi | input | 1 | 0 picks nibble bits 3:0, 1 picks bits 7:4 |
| res_out | output | 64 | Registered result |
| res_done | output | 1 | One-cycle pulse when a new result is present |

## Verification
On every cycle the assertions check the reset values, the done pulse after each strobe and its absence otherwise, that the result stays steady between strobes, and that all-zero or all-one operands return the expected table bit replicated. Bit-by-bit index ordering, the independence of lanes, the immunity to stray table bits and the composed three-input lookup depend on operand patterns. Only the bench's directed scenarios show these, by comparing against a model built from the requirements.

// File: rtl/lut2_pkg.sv
package lut2_pkg;
  localparam int LUT_IN  = 2;
  localparam int TBL_W   = 1 << LUT_IN;
  localparam int NUM_NIB = 2;
  localparam int SPAN_W  = TBL_W * NUM_NIB;
  typedef logic [TBL_W-1:0]  tbl_t;
  typedef logic [LUT_IN-1:0] idx_t;
endpackage

// File: rtl/lut2_table_pick.sv
module lut2_table_pick
  import lut2_pkg::*;
(
  input  logic [SPAN_W-1:0] span,
  input  logic              hi_sel,
  output tbl_t              tbl
);
  generate
    if (NUM_NIB == 2) begin : g_two
      assign tbl = hi_sel ? span[2*TBL_W-1:TBL_W] : span[TBL_W-1:0];
    end else begin : g_many
      assign tbl = span[TBL_W*int'(hi_sel) +: TBL_W];
    end
  endgenerate
endmodule

// File: rtl/lut2_lane_array.sv
module lut2_lane_array
  import lut2_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  tbl_t              tbl,
  output logic [DATA_W-1:0] res
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    idx_t lane_idx;
    assign lane_idx = {opb[i], opa[i]};
    assign res[i]   = tbl[lane_idx];
  end
endmodule

// File: rtl/dyn_lut2_unit.sv
module dyn_lut2_unit
  import lut2_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] tbl_reg,
  input  logic              tbl_hi,
  output logic [DATA_W-1:0] res_out,
  output logic              res_done
);
  tbl_t              cur_tbl;
  logic [DATA_W-1:0] comb_res;
  logic              unused_tbl_upper;

  assign unused_tbl_upper = ^tbl_reg[DATA_W-1:SPAN_W];

  lut2_table_pick u_pick (
    .span   (tbl_reg[SPAN_W-1:0]),
    .hi_sel (tbl_hi),
    .tbl    (cur_tbl)
  );

  lut2_lane_array #(.DATA_W(DATA_W)) u_lanes (
    .opa (src_a),
    .opb (src_b),
    .tbl (cur_tbl),
    .res (comb_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out  <= '0;
      res_done <= 1'b0;
    end else begin
      res_done <= in_valid;
      if (in_valid) res_out <= comb_res;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (res_done == 1'b0 && res_out == '0));

  // R7
  done_after_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_done);

  // R7
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_done);

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_out));

  // R2
  low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !tbl_hi && src_a == '0 && src_b == '0)
      |=> res_out == {DATA_W{$past(tbl_reg[0])}});

  // R3
  high_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && tbl_hi && (&src_a) && (&src_b))
      |=> res_out == {DATA_W{$past(tbl_reg[7])}});
endmodule

// File: tb/test_dyn_lut2_unit.sv
module test_dyn_lut2_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] src_a = '0, src_b = '0, tbl_reg = '0;
  logic        tbl_hi = 1'b0;
  logic [63:0] res_out;
  logic        res_done;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  dyn_lut2_unit i_dyn_lut2_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .tbl_reg(tbl_reg), .tbl_hi(tbl_hi), .res_out(res_out), .res_done(res_done)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [63:0] t, input logic hi);
    logic [3:0]  nib = hi ? t[7:4] : t[3:0];
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = nib[{b[i], a[i]}];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one operation: drive at negedge, result read at next negedge
  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [63:0] t,
                        input logic hi, output logic [63:0] r, output logic d);
    @(negedge clk);
    in_valid = 1'b1; src_a = a; src_b = b; tbl_reg = t; tbl_hi = hi;
    @(negedge clk);
    in_valid = 1'b0; src_a = ~a; src_b = ~b; tbl_reg = ~t; tbl_hi = ~hi;
    r = res_out; d = res_done;
  endtask

  task automatic t_reset();
    check("R1 done", {63'd0, res_done}, 64'd0);
    check("R1 result", res_out, 64'd0);
  endtask

  task automatic t_low_nibble();
    logic [63:0] r; logic d;
    for (int t = 0; t < 16; t++) begin
      run_op(64'hAAAA_AAAA_AAAA_AAAA, 64'hCCCC_CCCC_CCCC_CCCC, 64'(t), 1'b0, r, d);
      check("R2/R4 low nibble", r, model(64'hAAAA_AAAA_AAAA_AAAA, 64'hCCCC_CCCC_CCCC_CCCC, 64'(t), 1'b0));
    end
    run_op(64'hAAAA_AAAA_AAAA_AAAA, 64'h0, 64'h2, 1'b0, r, d);
    check("R4 index order a-low", r, 64'hAAAA_AAAA_AAAA_AAAA);
    run_op(64'h0, 64'hAAAA_AAAA_AAAA_AAAA, 64'h2, 1'b0, r, d);
    check("R4 index order b-high", r, 64'h0);
  endtask

  task automatic t_high_nibble();
    logic [63:0] r; logic d;
    for (int t = 0; t < 16; t++) begin
      run_op(64'h0F0F_3333_5555_00FF, 64'h00FF_0F0F_3333_5555, 64'(t << 4) | 64'h9, 1'b1, r, d);
      check("R3 high nibble", r, model(64'h0F0F_3333_5555_00FF, 64'h00FF_0F0F_3333_5555, 64'(t << 4), 1'b1));
    end
  endtask

  task automatic t_ignore_bits();
    logic [63:0] r; logic d;
    run_op(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'hFFFF_FFFF_FFFF_FF06, 1'b0, r, d);
    check("R6 stray bits, low", r, model(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h6, 1'b0));
    run_op(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'hA5A5_A5A5_A5A5_A587, 1'b1, r, d);
    check("R6 stray bits, high", r, model(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h80, 1'b1));
  endtask

  task automatic t_lanes();
    logic [63:0] r; logic d;
    for (int i = 0; i < 64; i += 7) begin
      run_op(64'd1 << i, 64'h0, 64'h2, 1'b0, r, d);
      check("R5 walking one", r, 64'd1 << i);
    end
    run_op(64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 64'h6, 1'b0, r, d);
    check("R5 edge lanes xor", r, 64'h0000_0000_0000_0001);
  endtask

  task automatic t_done_hold();
    logic [63:0] r; logic d;
    run_op(64'hDEAD_BEEF_0000_FFFF, 64'h0, 64'h2, 1'b0, r, d);
    check("R7 done pulse", {63'd0, d}, 64'd1);
    @(negedge clk);
    check("R7 done drops", {63'd0, res_done}, 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 hold", res_out, 64'hDEAD_BEEF_0000_FFFF);
    end
    @(negedge clk);
    in_valid = 1'b1; src_a = 64'h1; src_b = 64'h0; tbl_reg = 64'hF; tbl_hi = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; tbl_reg = 64'h0;
    check("R7 back-to-back first", {63'd0, res_done}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 back-to-back second", {63'd0, res_done}, 64'd1);
    check("R7 back-to-back result", res_out, 64'h0);
  endtask

  task automatic t_lut3();
    logic [63:0] x, y, c, p, q, lo, hi, r; logic d;
    logic [7:0] tbl8;
    x = 64'hF0F0_3C3C_AAAA_1234;
    y = 64'hCCCC_0FF0_5555_ABCD;
    c = 64'hFF00_F0F0_6666_9999;
    for (int k = 0; k < 4; k++) begin
      tbl8 = 8'h1B * 8'(k + 1) ^ 8'hA7;
      run_op(x, y, {56'h0, tbl8}, 1'b0, lo, d);
      run_op(x, y, {56'h0, tbl8}, 1'b1, hi, d);
      run_op(lo, c, 64'h2, 1'b0, p, d);
      run_op(hi, c, 64'h8, 1'b0, q, d);
      run_op(p, q, 64'hE, 1'b0, r, d);
      for (int i = 0; i < 64; i++) y[i] = y[i];
      begin
        logic [63:0] e;
        for (int i = 0; i < 64; i++) e[i] = tbl8[{c[i], y[i], x[i]}];
        check("R9 composed 3-input lookup", r, e);
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_low_nibble();
    t_high_nibble();
    t_ignore_bits();
    t_lanes();
    t_done_hold();
    t_lut3();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule